// File: doc/BRIEF.md
# Exception Entry Status Register Update

This block holds the 32-bit current processor status word of a 32-bit core, together with one saved status word for each of the five exception modes. When the one-cycle take strobe is high, the block does two things on the same clock edge. It copies the current status word into the saved slot that belongs to the target mode. It then replaces the current word with a new one, built field by field from the old word, a 32-bit system-control word and the target mode number.

Each field has its own rule on entry. Some fields keep their old value, some are cleared, some are forced to one, and some are copied from control bits. A few of the rules depend on which mode is being entered. A separate write port loads the current word directly when no exception is being taken. The saved-status output always shows the slot that belongs to the mode currently held in the status word.

Top module: `exc_status_unit`

## Requirements
- R1: Synchronous reset sets the status word to 32'h0000_01D3 (supervisor mode 5'b10011 with bits 8, 7 and 6 set) and clears all five saved slots.
- R2: On a take, bits 31:27 (condition and saturation flags), bit 24 and bits 19:16 keep their old values.
- R3: On a take, bits 26:25, 21:20 and 15:10 become zero.
- R4: On a take, bit 23 is loaded from control bit 31, bit 9 from control bit 25, and bit 5 from control bit 30.
- R5: On a take, bit 22 becomes one when control bit 23 is zero, and keeps its old value when control bit 23 is one.
- R6: On a take, bit 8 keeps its old value when the target mode is undefined (5'b11011) or supervisor (5'b10011), and becomes one for any other target mode.
- R7: On a take, bit 7 becomes one. Bit 6 becomes one when the target is fast interrupt (5'b10001) and keeps its old value otherwise.
- R8: On a take, bits 4:0 are loaded with the target mode.
- R9: On a take to a banked mode (5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011), that mode's slot receives the status word as it stood before the edge. The saved output shows the slot selected by bits 4:0 of the current word, and shows zero when that mode has no slot.
- R10: With the write enable high and no take, the status word loads the write data on the next edge and the saved slots do not change. When both are high, the take wins. With neither high, the status word holds.
- R11: A take to a mode without a slot changes no saved slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| take_i | input | 1 | Exception-take strobe, one cycle |
| take_mode_i | input | 5 | Target mode of the exception |
| ctl_word_i | input | 32 | System-control word that supplies the copied bits |
| wr_en_i | input | 1 | Direct write enable for the status word |
| wr_data_i | input | 32 | Direct write data |
| cur_status_o | output | 32 | Current status word |
| saved_status_o | output | 32 | Saved slot of the mode held in the current word |

## Verification
A field rule applied wrongly shows on the status output one cycle after the take, in the bits that rule owns. The bench therefore checks each group of bits against its own rule. A save written to the wrong slot, or not written at all, may stay hidden until the core returns to that mode. The bench therefore also uses the write port to switch modes and read back slots it has not used for a while, and it checks after every cycle that no slot was disturbed by a take to a mode without a slot.

// File: rtl/exc_status_pkg.sv
`timescale 1ns/1ps
package exc_status_pkg;
   localparam int unsigned SR_W      = 32;
   localparam int unsigned MODE_W    = 5;
   localparam int unsigned NUM_BANKS = 5;
   localparam int unsigned BANK_IW   = $clog2(NUM_BANKS);

   typedef enum logic [MODE_W-1:0] {
      MODE_USER = 5'b10000,
      MODE_FAST = 5'b10001,
      MODE_INTR = 5'b10010,
      MODE_SUPV = 5'b10011,
      MODE_ABRT = 5'b10111,
      MODE_UNDF = 5'b11011,
      MODE_SYST = 5'b11111
   } mode_e;

   // bit positions of the status word
   localparam int unsigned B_FLAG_HI  = 31;
   localparam int unsigned B_FLAG_LO  = 27;
   localparam int unsigned B_CX_HI_H  = 26;
   localparam int unsigned B_CX_HI_L  = 25;
   localparam int unsigned B_CONST_T  = 24;
   localparam int unsigned B_SPEC_SF  = 23;
   localparam int unsigned B_PRIV_GD  = 22;
   localparam int unsigned B_RSVD21   = 21;
   localparam int unsigned B_ILLEGAL  = 20;
   localparam int unsigned B_GE_HI    = 19;
   localparam int unsigned B_GE_LO    = 16;
   localparam int unsigned B_CX_LO_H  = 15;
   localparam int unsigned B_CX_LO_L  = 10;
   localparam int unsigned B_ENDIAN   = 9;
   localparam int unsigned B_MSK_ASY  = 8;
   localparam int unsigned B_MSK_IRQ  = 7;
   localparam int unsigned B_MSK_FIQ  = 6;
   localparam int unsigned B_CMPCT    = 5;

   // control word source positions
   localparam int unsigned C_SPEC_SF  = 31;
   localparam int unsigned C_CMPCT    = 30;
   localparam int unsigned C_ENDIAN   = 25;
   localparam int unsigned C_GD_KEEP  = 23;

   localparam logic [SR_W-1:0] RESET_WORD =
      SR_W'({MODE_SUPV}) | (SR_W'(1) << B_MSK_ASY) |
      (SR_W'(1) << B_MSK_IRQ) | (SR_W'(1) << B_MSK_FIQ);

   function automatic logic [MODE_W-1:0] bank_mode(input int unsigned idx);
      case (idx)
         0:       bank_mode = MODE_FAST;
         1:       bank_mode = MODE_INTR;
         2:       bank_mode = MODE_SUPV;
         3:       bank_mode = MODE_ABRT;
         default: bank_mode = MODE_UNDF;
      endcase
   endfunction
endpackage

// File: rtl/exc_entry_calc.sv
`timescale 1ns/1ps
module exc_entry_calc
   import exc_status_pkg::*;
#(
   parameter int unsigned W  = SR_W,
   parameter int unsigned MW = MODE_W
) (
   input  logic [W-1:0]  old_i,
   input  logic [MW-1:0] mode_i,
   input  logic [W-1:0]  ctl_i,
   output logic [W-1:0]  new_o
);
   if (W != 32) begin : g_bad_w
      $error("exc_entry_calc: word width must be 32");
   end
   if (MW != 5) begin : g_bad_mw
      $error("exc_entry_calc: mode width must be 5");
   end

   logic keep_async;
   logic force_fiq;

   always_comb begin
      keep_async = (mode_i == MODE_UNDF) || (mode_i == MODE_SUPV);
      force_fiq  = (mode_i == MODE_FAST);
   end

   always_comb begin
      new_o = '0;
      // retained fields
      new_o[B_FLAG_HI:B_FLAG_LO] = old_i[B_FLAG_HI:B_FLAG_LO];
      new_o[B_CONST_T]           = old_i[B_CONST_T];
      new_o[B_GE_HI:B_GE_LO]     = old_i[B_GE_HI:B_GE_LO];
      // fields copied from control
      new_o[B_SPEC_SF]           = ctl_i[C_SPEC_SF];
      new_o[B_ENDIAN]            = ctl_i[C_ENDIAN];
      new_o[B_CMPCT]             = ctl_i[C_CMPCT];
      // guard bit: forced unless control asks to keep it
      new_o[B_PRIV_GD]           = ctl_i[C_GD_KEEP] ? old_i[B_PRIV_GD] : 1'b1;
      // mode dependent masks
      new_o[B_MSK_ASY]           = keep_async ? old_i[B_MSK_ASY] : 1'b1;
      new_o[B_MSK_IRQ]           = 1'b1;
      new_o[B_MSK_FIQ]           = force_fiq ? 1'b1 : old_i[B_MSK_FIQ];
      new_o[MW-1:0]              = mode_i;
      // conditional-execution state, illegal bit and reserved bits stay zero
   end
endmodule

// File: rtl/exc_bank_decode.sv
`timescale 1ns/1ps
module exc_bank_decode
   import exc_status_pkg::*;
#(
   parameter int unsigned MW = MODE_W,
   parameter int unsigned NB = NUM_BANKS
) (
   input  logic [MW-1:0] mode_i,
   output logic [NB-1:0] hit_o
);
   if (NB != 5) begin : g_bad_nb
      $error("exc_bank_decode: five banked modes are required");
   end

   for (genvar g = 0; g < NB; g++) begin : g_hit
      assign hit_o[g] = (mode_i == bank_mode(g));
   end
endmodule

// File: rtl/exc_saved_bank.sv
`timescale 1ns/1ps
module exc_saved_bank
   import exc_status_pkg::*;
#(
   parameter int unsigned W  = SR_W,
   parameter int unsigned NB = NUM_BANKS
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [NB-1:0] wr_sel_i,
   input  logic [W-1:0]  wr_data_i,
   input  logic [NB-1:0] rd_sel_i,
   output logic [W-1:0]  rd_data_o
);
   logic [W-1:0] slot_q [NB];
   logic [W-1:0] gated  [NB];

   for (genvar g = 0; g < NB; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (rst) begin
            slot_q[g] <= '0;
         end else if (wr_sel_i[g]) begin
            slot_q[g] <= wr_data_i;
         end
      end
      assign gated[g] = rd_sel_i[g] ? slot_q[g] : '0;
   end

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < NB; i++) begin
         rd_data_o = rd_data_o | gated[i];
      end
   end
endmodule

// File: rtl/exc_cur_reg.sv
`timescale 1ns/1ps
module exc_cur_reg
   import exc_status_pkg::*;
#(
   parameter int unsigned W = SR_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         take_i,
   input  logic [W-1:0] entry_i,
   input  logic         wr_en_i,
   input  logic [W-1:0] wr_data_i,
   output logic [W-1:0] cur_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         cur_o <= RESET_WORD;
      end else if (take_i) begin
         cur_o <= entry_i;
      end else if (wr_en_i) begin
         cur_o <= wr_data_i;
      end
   end
endmodule

// File: rtl/exc_status_unit.sv
`timescale 1ns/1ps
module exc_status_unit
   import exc_status_pkg::*;
#(
   parameter int unsigned STATUS_W = SR_W,
   parameter int unsigned MODE_BITS = MODE_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 take_i,
   input  logic [MODE_BITS-1:0] take_mode_i,
   input  logic [STATUS_W-1:0]  ctl_word_i,
   input  logic                 wr_en_i,
   input  logic [STATUS_W-1:0]  wr_data_i,
   output logic [STATUS_W-1:0]  cur_status_o,
   output logic [STATUS_W-1:0]  saved_status_o
);
   localparam int unsigned NB = NUM_BANKS;

   if (STATUS_W != SR_W) begin : g_bad_sw
      $error("exc_status_unit: STATUS_W must equal the package word width");
   end

   logic [STATUS_W-1:0] entry_word;
   logic [NB-1:0]       tgt_hit;
   logic [NB-1:0]       cur_hit;
   logic [NB-1:0]       save_sel;

   exc_entry_calc #(.W(STATUS_W), .MW(MODE_BITS)) u_calc (
      .old_i  (cur_status_o),
      .mode_i (take_mode_i),
      .ctl_i  (ctl_word_i),
      .new_o  (entry_word)
   );

   exc_bank_decode #(.MW(MODE_BITS), .NB(NB)) u_tgt_dec (
      .mode_i (take_mode_i),
      .hit_o  (tgt_hit)
   );

   exc_bank_decode #(.MW(MODE_BITS), .NB(NB)) u_cur_dec (
      .mode_i (cur_status_o[MODE_BITS-1:0]),
      .hit_o  (cur_hit)
   );

   assign save_sel = take_i ? tgt_hit : '0;

   exc_saved_bank #(.W(STATUS_W), .NB(NB)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .wr_sel_i  (save_sel),
      .wr_data_i (cur_status_o),
      .rd_sel_i  (cur_hit),
      .rd_data_o (saved_status_o)
   );

   exc_cur_reg #(.W(STATUS_W)) u_cur (
      .clk       (clk),
      .rst       (rst),
      .take_i    (take_i),
      .entry_i   (entry_word),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .cur_o     (cur_status_o)
   );
endmodule

// File: rtl/exc_status_checker.sv
`timescale 1ns/1ps
module exc_status_checker (
   input logic        clk,
   input logic        rst,
   input logic        take_i,
   input logic [4:0]  take_mode_i,
   input logic [31:0] ctl_word_i,
   input logic        wr_en_i,
   input logic [31:0] wr_data_i,
   input logic [31:0] cur_status_o,
   input logic [31:0] saved_status_o
);
   logic banked_tgt;
   assign banked_tgt = (take_mode_i == 5'b10001) || (take_mode_i == 5'b10010) ||
                       (take_mode_i == 5'b10011) || (take_mode_i == 5'b10111) ||
                       (take_mode_i == 5'b11011);

   a_r1_reset_word: assert property (@(posedge clk)
      rst |=> cur_status_o == 32'h0000_01D3);

   a_r2_kept: assert property (@(posedge clk) disable iff (rst)
      take_i |=> {cur_status_o[31:27], cur_status_o[24], cur_status_o[19:16]} ==
                 $past({cur_status_o[31:27], cur_status_o[24], cur_status_o[19:16]}));

   a_r3_cleared: assert property (@(posedge clk) disable iff (rst)
      take_i |=> (cur_status_o & 32'h0630_FC00) == 32'h0);

   a_r4_copied: assert property (@(posedge clk) disable iff (rst)
      take_i |=> cur_status_o[23] == $past(ctl_word_i[31]) &&
                 cur_status_o[9]  == $past(ctl_word_i[25]) &&
                 cur_status_o[5]  == $past(ctl_word_i[30]));

   a_r5_guard_forced: assert property (@(posedge clk) disable iff (rst)
      (take_i && !ctl_word_i[23]) |=> cur_status_o[22]);

   a_r6_async_set: assert property (@(posedge clk) disable iff (rst)
      (take_i && take_mode_i != 5'b11011 && take_mode_i != 5'b10011) |=> cur_status_o[8]);

   a_r7_irq_mask: assert property (@(posedge clk) disable iff (rst)
      take_i |=> cur_status_o[7]);

   a_r8_mode: assert property (@(posedge clk) disable iff (rst)
      take_i |=> cur_status_o[4:0] == $past(take_mode_i));

   a_r9_saved: assert property (@(posedge clk) disable iff (rst)
      (take_i && banked_tgt) |=> saved_status_o == $past(cur_status_o));

   a_r10_write: assert property (@(posedge clk) disable iff (rst)
      (wr_en_i && !take_i) |=> cur_status_o == $past(wr_data_i));

   a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      (!wr_en_i && !take_i) |=> $stable(cur_status_o) && $stable(saved_status_o));
endmodule

bind exc_status_unit exc_status_checker u_chk (
   .clk            (clk),
   .rst            (rst),
   .take_i         (take_i),
   .take_mode_i    (take_mode_i),
   .ctl_word_i     (ctl_word_i),
   .wr_en_i        (wr_en_i),
   .wr_data_i      (wr_data_i),
   .cur_status_o   (cur_status_o),
   .saved_status_o (saved_status_o)
);

// File: tb/exc_status_unit_bench.sv
`timescale 1ns/1ps
module exc_status_unit_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        take_i = 1'b0;
   logic [4:0]  take_mode_i = 5'b10000;
   logic [31:0] ctl_word_i = '0;
   logic        wr_en_i = 1'b0;
   logic [31:0] wr_data_i = '0;
   logic [31:0] cur_status_o;
   logic [31:0] saved_status_o;

   int errors = 0;
   int checks = 0;

   logic [31:0] m_cur;
   logic [31:0] m_bank [5];

   always #10 clk = ~clk;

   exc_status_unit u_exc_status_unit (
      .clk(clk), .rst(rst), .take_i(take_i), .take_mode_i(take_mode_i),
      .ctl_word_i(ctl_word_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
      .cur_status_o(cur_status_o), .saved_status_o(saved_status_o)
   );

   function automatic int slot_of(input logic [4:0] m);
      case (m)
         5'b10001: return 0;
         5'b10010: return 1;
         5'b10011: return 2;
         5'b10111: return 3;
         5'b11011: return 4;
         default:  return -1;
      endcase
   endfunction

   function automatic logic [31:0] entry_model(input logic [31:0] o,
                                               input logic [4:0] m,
                                               input logic [31:0] c);
      logic [31:0] r;
      r = 32'h0;
      r = r | (o & 32'hF90F_0000);
      if (c[31]) r = r | 32'h0080_0000;
      if (c[25]) r = r | 32'h0000_0200;
      if (c[30]) r = r | 32'h0000_0020;
      if (!c[23] || o[22]) r = r | 32'h0040_0000;
      if ((m != 5'b11011 && m != 5'b10011) || o[8]) r = r | 32'h0000_0100;
      r = r | 32'h0000_0080;
      if (m == 5'b10001 || o[6]) r = r | 32'h0000_0040;
      r = r | {27'h0, m};
      return r;
   endfunction

   function automatic logic [31:0] model_saved();
      int s;
      s = slot_of(m_cur[4:0]);
      return (s < 0) ? 32'h0 : m_bank[s];
   endfunction

   task automatic check(input string tag, input logic [31:0] act,
                        input logic [31:0] exp, input logic [31:0] mask);
      checks++;
      if ((act & mask) !== (exp & mask)) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h (mask %08h)", tag, act & mask, exp & mask, mask);
      end
   endtask

   // one clock: drive at negedge, update model at posedge, check at next negedge
   task automatic step(input logic tk, input logic [4:0] md, input logic [31:0] cw,
                       input logic we, input logic [31:0] wd);
      logic [31:0] old;
      int s;
      take_i = tk; take_mode_i = md; ctl_word_i = cw; wr_en_i = we; wr_data_i = wd;
      @(posedge clk);
      old = m_cur;
      if (tk) begin
         s = slot_of(md);
         if (s >= 0) m_bank[s] = old;
         m_cur = entry_model(old, md, cw);
      end else if (we) begin
         m_cur = wd;
      end
      @(negedge clk);
      take_i = 1'b0; wr_en_i = 1'b0;
      if (tk) begin
         check("R2 kept fields", cur_status_o, m_cur, 32'hF90F_0000);
         check("R3 cleared fields", cur_status_o, m_cur, 32'h0630_FC00);
         check("R4 copied bits", cur_status_o, m_cur, 32'h0080_0220);
         check("R5 guard bit", cur_status_o, m_cur, 32'h0040_0000);
         check("R6 async mask", cur_status_o, m_cur, 32'h0000_0100);
         check("R7 irq/fiq masks", cur_status_o, m_cur, 32'h0000_00C0);
         check("R8 mode field", cur_status_o, m_cur, 32'h0000_001F);
         if (slot_of(md) >= 0) check("R9 saved slot", saved_status_o, model_saved(), '1);
         else                  check("R11 unbanked take", saved_status_o, model_saved(), '1);
      end else begin
         check("R10 status word", cur_status_o, m_cur, '1);
         check("R10 saved view", saved_status_o, model_saved(), '1);
      end
   endtask

   function automatic logic [4:0] pick_mode(input int unsigned r);
      case (r % 8)
         0: return 5'b10001;
         1: return 5'b10010;
         2: return 5'b10011;
         3: return 5'b10111;
         4: return 5'b11011;
         5: return 5'b10000;
         6: return 5'b11111;
         default: return 5'($urandom);
      endcase
   endfunction

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));
      m_cur = 32'h0000_01D3;
      for (int i = 0; i < 5; i++) m_bank[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: reset state, and every slot empty
      check("R1 reset word", cur_status_o, 32'h0000_01D3, '1);
      check("R1 reset slot (supervisor)", saved_status_o, 32'h0, '1);
      for (int i = 0; i < 5; i++) begin
         logic [4:0] bm;
         case (i) 0: bm = 5'b10001; 1: bm = 5'b10010; 2: bm = 5'b10011;
                  3: bm = 5'b10111; default: bm = 5'b11011; endcase
         step(1'b0, 5'b0, 32'h0, 1'b1, {27'h0, bm});
         check("R1 reset slot", saved_status_o, 32'h0, '1);
      end
      // directed: all-ones old word, guard keep set, into supervisor (R5 keep, R6 keep)
      step(1'b0, 5'b0, 32'h0, 1'b1, 32'hFFFF_FFE0 | 32'h10);
      step(1'b1, 5'b10011, 32'h0080_0000, 1'b0, 32'h0);
      // directed: all-zero old bits, into fast interrupt with control zero (R5 forced, R7 F set)
      step(1'b0, 5'b0, 32'h0, 1'b1, 32'h0000_0010);
      step(1'b1, 5'b10001, 32'h0000_0000, 1'b0, 32'h0);
      // directed: into undefined from a word with bit 8 clear (R6 keep zero)
      step(1'b0, 5'b0, 32'h0, 1'b1, 32'hA500_0E10);
      step(1'b1, 5'b11011, 32'hC280_0000, 1'b0, 32'h0);
      // directed: take and write together, take wins (R10)
      step(1'b1, 5'b10111, 32'h4200_0000, 1'b1, 32'h1234_5670);
      check("R10 take beats write", cur_status_o, m_cur, '1);
      // directed: take to an unbanked mode leaves every slot (R11)
      step(1'b1, 5'b11111, 32'h0, 1'b0, 32'h0);
      for (int i = 0; i < 5; i++) begin
         logic [4:0] bm;
         case (i) 0: bm = 5'b10001; 1: bm = 5'b10010; 2: bm = 5'b10011;
                  3: bm = 5'b10111; default: bm = 5'b11011; endcase
         step(1'b0, 5'b0, 32'h0, 1'b1, {27'h0, bm});
         check("R11 slot untouched", saved_status_o, m_bank[i], '1);
      end
      // random mix
      for (int n = 0; n < 3000; n++) begin
         int unsigned r;
         r = $urandom;
         step((r % 10) < 4, pick_mode($urandom), $urandom, (r % 7) < 3, $urandom);
      end
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule